// File: doc/BRIEF.md
# Event-Triggered Transfer Controller

This block moves one byte over a simple synchronous memory bus each time a peripheral raises an event. A descriptor held in local registers sets the transfer. It holds the source and destination addresses, how each of them steps, the transfer count, an interrupt-select bit, a chain bit and a table address. For each transfer the engine reads the source, writes the destination, steps both addresses and decrements the count. It then either clears the peripheral's ready flag or passes the event to the CPU as an interrupt.

When the count runs out, the engine normally drops its enable bit and interrupts the CPU. With chaining set, it instead fetches the next upper address byte from a table and keeps running. This lets a long run of events fill a buffer made of several blocks, with no CPU work between blocks. A typical use is draining a serial receiver into RAM: a fixed source and an incrementing destination.

Top module: `xfer_trig_ctrl`

## Requirements
- R1: After reset `busy_o`, `en_o`, `mem_req_o`, `irq_o` and `flag_clr_o` are all low.
- R2: A `cfg_we_i` pulse while idle loads every descriptor field and sets `en_o` to `cfg_en_i`. A `cfg_we_i` pulse while busy changes nothing.
- R3: `evt_i` is sampled only while `en_o` is high. An event that arrives during a transfer is held as pending and served once the engine is idle.
- R4: Each transfer is a read at the source address followed by a write of the read byte to the destination address. The engine has one access outstanding at a time, and it keeps `mem_req_o`, `mem_we_o` and `mem_addr_o` steady until `mem_rdy_i` is high.
- R5: Each address steps after every transfer according to its 2-bit mode: 00 and 01 leave it fixed, 10 adds one and 11 subtracts one.
- R6: The count drops by one per transfer. A loaded count of 0 gives 2^CNT_W transfers.
- R7: When interrupt-select is 0 and a transfer leaves the count non-zero, the engine gives one `flag_clr_o` pulse and no interrupt.
- R8: When a transfer brings the count to zero with chaining off, `en_o` drops, `flag_clr_o` stays low and `irq_o` gives one pulse.
- R9: With interrupt-select set to 1, every transfer gives one `irq_o` pulse and no `flag_clr_o`. The terminal transfer still drops `en_o`.
- R10: When a transfer brings the count to zero with chaining on, the engine reads one byte at the table address and writes it into the top DATA_W bits of the destination address. The lower bits are kept and the table address adds one. `en_o` stays high, there is no interrupt, and `flag_clr_o` pulses once when interrupt-select is 0.
- R11: `busy_o` is high from the cycle after a transfer starts until the engine is idle again. While `busy_o` is high, `en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor load strobe |
| cfg_en_i | input | 1 | Enable value loaded with the descriptor |
| cfg_src_mode_i | input | 2 | Source step mode |
| cfg_dst_mode_i | input | 2 | Destination step mode |
| cfg_src_i | input | ADDR_W | Source address |
| cfg_dst_i | input | ADDR_W | Destination address |
| cfg_tbl_i | input | ADDR_W | Address of the chained upper-byte table |
| cfg_cnt_i | input | CNT_W | Transfer count, 0 means 2^CNT_W |
| cfg_chain_i | input | 1 | Run the table reload when the count reaches zero |
| cfg_irq_sel_i | input | 1 | Interrupt the CPU after every transfer |
| evt_i | input | 1 | Peripheral event, one cycle per event |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | Bus write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Bus address |
| mem_wdata_o | output | DATA_W | Bus write data |
| mem_rdata_i | input | DATA_W | Bus read data, valid with mem_rdy_i |
| mem_rdy_i | input | 1 | Access completes in this cycle |
| irq_o | output | 1 | One-cycle CPU interrupt pulse |
| flag_clr_o | output | 1 | One-cycle pulse clearing the peripheral ready flag |
| busy_o | output | 1 | Transfer in progress |
| en_o | output | 1 | Enable bit |

## Verification
Some rules are checked on every cycle. A stalled access must hold its request, direction and address. The interrupt and flag-clear pulses must never coincide. A transfer may start only while enabled. Busy implies enabled. The enable bit may fall without a descriptor load only together with an interrupt. The bench scenarios are needed for the rest: the byte values and address sequences, the 2^CNT_W length of a zero count, table reloads at the block boundaries, pending events, and loads or events that must be ignored.

// File: rtl/xfer_trig_pkg.sv
package xfer_trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD    = 2'd1,
    ST_WR    = 2'd2,
    ST_CHAIN = 2'd3
  } xfer_st_e;

  typedef enum logic [1:0] {
    AM_FIX  = 2'b00,
    AM_FIX1 = 2'b01,
    AM_INC  = 2'b10,
    AM_DEC  = 2'b11
  } addr_mode_e;

endpackage

// File: rtl/xfer_trig_step.sv
module xfer_trig_step
  import xfer_trig_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    unique case (addr_mode_e'(mode_i))
      AM_INC:  addr_o = addr_i + ADDR_W'(1);
      AM_DEC:  addr_o = addr_i - ADDR_W'(1);
      default: addr_o = addr_i;
    endcase
  end

endmodule

// File: rtl/xfer_trig_desc.sv
module xfer_trig_desc #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_ok_i,
  input  logic              cfg_en_i,
  input  logic [1:0]        cfg_src_mode_i,
  input  logic [1:0]        cfg_dst_mode_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  input  logic [ADDR_W-1:0] cfg_tbl_i,
  input  logic [CNT_W-1:0]  cfg_cnt_i,
  input  logic              cfg_chain_i,
  input  logic              cfg_irq_sel_i,
  input  logic              step_i,
  input  logic              chain_ld_i,
  input  logic [DATA_W-1:0] chain_byte_i,
  input  logic              en_clr_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [ADDR_W-1:0] tbl_o,
  output logic              last_o,
  output logic              chain_o,
  output logic              irq_sel_o,
  output logic              en_o
);

  localparam int unsigned LOW_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] src_q, dst_q, tbl_q, src_nxt, dst_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        sm_q, dm_q;
  logic              chain_q, isel_q, en_q;

  xfer_trig_step #(.ADDR_W(ADDR_W)) i_src_step (.addr_i(src_q), .mode_i(sm_q), .addr_o(src_nxt));
  xfer_trig_step #(.ADDR_W(ADDR_W)) i_dst_step (.addr_i(dst_q), .mode_i(dm_q), .addr_o(dst_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      dst_q   <= '0;
      tbl_q   <= '0;
      cnt_q   <= '0;
      sm_q    <= '0;
      dm_q    <= '0;
      chain_q <= 1'b0;
      isel_q  <= 1'b0;
      en_q    <= 1'b0;
    end else if (cfg_ok_i) begin
      src_q   <= cfg_src_i;
      dst_q   <= cfg_dst_i;
      tbl_q   <= cfg_tbl_i;
      cnt_q   <= cfg_cnt_i;
      sm_q    <= cfg_src_mode_i;
      dm_q    <= cfg_dst_mode_i;
      chain_q <= cfg_chain_i;
      isel_q  <= cfg_irq_sel_i;
      en_q    <= cfg_en_i;
    end else begin
      if (step_i) begin
        src_q <= src_nxt;
        dst_q <= dst_nxt;
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (chain_ld_i) begin
        // reload upper address byte, keep the wrapped low part
        dst_q <= {chain_byte_i, dst_q[LOW_W-1:0]};
        tbl_q <= tbl_q + ADDR_W'(1);
      end
      if (en_clr_i) en_q <= 1'b0;
    end
  end

  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign tbl_o     = tbl_q;
  assign last_o    = (cnt_q == CNT_W'(1));
  assign chain_o   = chain_q;
  assign irq_sel_o = isel_q;
  assign en_o      = en_q;

endmodule

// File: rtl/xfer_trig_seq.sv
module xfer_trig_seq
  import xfer_trig_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              evt_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] tbl_i,
  input  logic              last_i,
  input  logic              chain_i,
  input  logic              irq_sel_i,
  input  logic              mem_rdy_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              step_o,
  output logic              chain_ld_o,
  output logic              en_clr_o,
  output logic              irq_o,
  output logic              flag_clr_o,
  output logic              busy_o
);

  xfer_trig_pkg::xfer_st_e state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic pend_q, irq_q, clr_q, start;

  assign start      = (state_q == ST_IDLE) && en_i && (pend_q || evt_i);
  assign step_o     = (state_q == ST_WR) && mem_rdy_i;
  assign chain_ld_o = (state_q == ST_CHAIN) && mem_rdy_i;
  assign en_clr_o   = step_o && last_i && !chain_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_RD;
      ST_RD:    if (mem_rdy_i) state_d = ST_WR;
      ST_WR:    if (mem_rdy_i) state_d = (last_i && chain_i) ? ST_CHAIN : ST_IDLE;
      ST_CHAIN: if (mem_rdy_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_RD) && mem_rdy_i) data_q <= mem_rdata_i;
      if (!en_i || start)                       pend_q <= 1'b0;
      else if (evt_i && state_q != ST_IDLE)     pend_q <= 1'b1;
      irq_q <= step_o && (irq_sel_i || (last_i && !chain_i));
      clr_q <= !irq_sel_i && ((step_o && !last_i) || chain_ld_o);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_RD:    mem_addr_o = src_i;
      ST_WR:    mem_addr_o = dst_i;
      ST_CHAIN: mem_addr_o = tbl_i;
      default:  mem_addr_o = src_i;
    endcase
  end

  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_wdata_o = data_q;
  assign irq_o       = irq_q;
  assign flag_clr_o  = clr_q;
  assign busy_o      = (state_q != ST_IDLE);

  // R4: stalled access holds its request, direction and address
  a_r4_hold_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));

  // R7: flag clear and interrupt never in the same cycle
  a_r7_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && flag_clr_o));

  // R3: a transfer only starts while enabled
  a_r3_start_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(en_i));

endmodule

// File: rtl/xfer_trig_ctrl.sv
module xfer_trig_ctrl #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic [1:0]        cfg_src_mode_i,
  input  logic [1:0]        cfg_dst_mode_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  input  logic [ADDR_W-1:0] cfg_tbl_i,
  input  logic [CNT_W-1:0]  cfg_cnt_i,
  input  logic              cfg_chain_i,
  input  logic              cfg_irq_sel_i,
  input  logic              evt_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic              irq_o,
  output logic              flag_clr_o,
  output logic              busy_o,
  output logic              en_o
);

  logic [ADDR_W-1:0] src, dst, tbl;
  logic last, chain, irq_sel, en, step, chain_ld, en_clr, busy;

  xfer_trig_desc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_desc (
    .clk_i, .rst_ni,
    .cfg_ok_i      (cfg_we_i && !busy),
    .cfg_en_i, .cfg_src_mode_i, .cfg_dst_mode_i,
    .cfg_src_i, .cfg_dst_i, .cfg_tbl_i, .cfg_cnt_i,
    .cfg_chain_i, .cfg_irq_sel_i,
    .step_i        (step),
    .chain_ld_i    (chain_ld),
    .chain_byte_i  (mem_rdata_i),
    .en_clr_i      (en_clr),
    .src_o         (src),
    .dst_o         (dst),
    .tbl_o         (tbl),
    .last_o        (last),
    .chain_o       (chain),
    .irq_sel_o     (irq_sel),
    .en_o          (en)
  );

  xfer_trig_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk_i, .rst_ni,
    .en_i        (en),
    .evt_i,
    .src_i       (src),
    .dst_i       (dst),
    .tbl_i       (tbl),
    .last_i      (last),
    .chain_i     (chain),
    .irq_sel_i   (irq_sel),
    .mem_rdy_i, .mem_rdata_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .step_o      (step),
    .chain_ld_o  (chain_ld),
    .en_clr_o    (en_clr),
    .irq_o, .flag_clr_o,
    .busy_o      (busy)
  );

  assign busy_o = busy;
  assign en_o   = en;

  // R11: never busy while disabled
  a_r11_busy_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> en_o);

  // R8: enable drops without a descriptor load only with a CPU interrupt
  a_r8_en_fall_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(en_o) && !$past(cfg_we_i)) |-> irq_o);

endmodule

// File: tb/test_xfer_trig_ctrl.sv
`timescale 1ns/1ps
module test_xfer_trig_ctrl;

  localparam int AW = 24;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam logic [AW-1:0] PER = 24'h00FF00;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 0, cfg_en_i = 0, cfg_chain_i = 0, cfg_irq_sel_i = 0, evt_i = 0;
  logic [1:0] cfg_src_mode_i = 0, cfg_dst_mode_i = 0;
  logic [AW-1:0] cfg_src_i = 0, cfg_dst_i = 0, cfg_tbl_i = 0;
  logic [CW-1:0] cfg_cnt_i = 0;
  logic mem_req_o, mem_we_o, mem_rdy_i = 0, irq_o, flag_clr_o, busy_o, en_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;

  logic [DW-1:0] pdata = 0;
  logic [DW-1:0] tbl_mem [16];
  logic [AW-1:0] wa[$], ra[$];
  logic [DW-1:0] wd[$];
  int irq_n = 0, clr_n = 0, wait_n = 0, wcnt = 0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  xfer_trig_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_xfer_trig_ctrl (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_en_i, .cfg_src_mode_i, .cfg_dst_mode_i,
    .cfg_src_i, .cfg_dst_i, .cfg_tbl_i, .cfg_cnt_i, .cfg_chain_i, .cfg_irq_sel_i,
    .evt_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .mem_rdy_i, .irq_o, .flag_clr_o, .busy_o, .en_o
  );

  function automatic logic [DW-1:0] rd_model(logic [AW-1:0] a);
    return (a == PER) ? pdata : tbl_mem[a[3:0]];
  endfunction

  assign mem_rdata_i = rd_model(mem_addr_o);

  // bus responder with programmable wait states
  always @(negedge clk) begin
    if (mem_rdy_i) begin
      mem_rdy_i = 1'b0;
      wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt >= wait_n) mem_rdy_i = 1'b1;
      else wcnt++;
    end
  end

  always @(posedge clk) begin
    if (mem_req_o && mem_rdy_i) begin
      if (mem_we_o) begin wa.push_back(mem_addr_o); wd.push_back(mem_wdata_o); end
      else ra.push_back(mem_addr_o);
    end
    if (irq_o) irq_n++;
    if (flag_clr_o) clr_n++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    wa.delete(); wd.delete(); ra.delete();
    irq_n = 0; clr_n = 0;
  endtask

  task automatic load(logic [1:0] sm, logic [1:0] dm, logic [AW-1:0] src, logic [AW-1:0] dst,
                      logic [AW-1:0] tbl, logic [CW-1:0] cnt, logic ch, logic isel, logic en);
    @(negedge clk);
    cfg_src_mode_i = sm; cfg_dst_mode_i = dm; cfg_src_i = src; cfg_dst_i = dst;
    cfg_tbl_i = tbl; cfg_cnt_i = cnt; cfg_chain_i = ch; cfg_irq_sel_i = isel;
    cfg_en_i = en; cfg_we_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); evt_i = 1'b1;
    @(negedge clk); evt_i = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      if (!busy_o) q++; else q = 0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 en", en_o, 0);
    chk("R1 req", mem_req_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 flag_clr", flag_clr_o, 0);
  endtask

  task automatic t_normal();
    clear_logs();
    load(2'b00, 2'b10, PER, 24'h000100, 24'h0, 4'd3, 1'b0, 1'b0, 1'b1);
    chk("R2 enable loaded", en_o, 1);
    for (int i = 0; i < 3; i++) begin
      pdata = 8'hA0 + 8'(i);
      @(negedge clk); evt_i = 1'b1;
      @(negedge clk); evt_i = 1'b0;
      if (i == 0) chk("R11 busy after start", busy_o, 1);
      wait_idle();
    end
    chk("R11 idle after transfers", busy_o, 0);
    chk("R4 write count", wa.size(), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R5 dst increments", wa[i], 24'h000100 + i);
      chk("R4 byte copied", wd[i], 8'hA0 + i);
      chk("R5 src fixed", ra[i], PER);
    end
    chk("R7 flag clears", clr_n, 2);
    chk("R8 one irq", irq_n, 1);
    chk("R8 enable dropped", en_o, 0);
    fire();
    wait_idle();
    chk("R3 event ignored when disabled", wa.size(), 3);
  endtask

  task automatic t_pending();
    clear_logs();
    wait_n = 2;
    load(2'b10, 2'b11, 24'h001000, 24'h000080, 24'h0, 4'd5, 1'b0, 1'b0, 1'b1);
    @(negedge clk); evt_i = 1'b1;
    @(negedge clk);            // second event lands while busy
    @(negedge clk); evt_i = 1'b0;
    wait_idle();
    chk("R3 pending served", wa.size(), 2);
    chk("R5 dst decrements a", wa[0], 24'h000080);
    chk("R5 dst decrements b", wa[1], 24'h00007F);
    chk("R5 src increments", ra[1], 24'h001001);
    chk("R4 data a", wd[0], tbl_mem[0]);
    chk("R4 data b", wd[1], tbl_mem[1]);
    // descriptor load while busy must be dropped
    @(negedge clk); evt_i = 1'b1;
    @(negedge clk); evt_i = 1'b0;
    load(2'b00, 2'b10, PER, 24'h555555, 24'h0, 4'd1, 1'b0, 1'b1, 1'b0);
    wait_idle();
    chk("R2 load ignored, enable kept", en_o, 1);
    chk("R2 load ignored, dst kept", wa[2], 24'h00007E);
    fire();
    wait_idle();
    chk("R2 load ignored, dst continues", wa[3], 24'h00007D);
    chk("R7 no irq mid run", irq_n, 0);
    wait_n = 0;
  endtask

  task automatic t_isel();
    clear_logs();
    load(2'b00, 2'b10, PER, 24'h000300, 24'h0, 4'd2, 1'b0, 1'b1, 1'b1);
    fire(); wait_idle();
    fire(); wait_idle();
    chk("R9 irq every transfer", irq_n, 2);
    chk("R9 no flag clear", clr_n, 0);
    chk("R9 enable dropped", en_o, 0);
  endtask

  task automatic t_chain();
    clear_logs();
    tbl_mem[0] = 8'h21;
    tbl_mem[1] = 8'h20;
    load(2'b00, 2'b10, PER, 24'h200000, 24'h001000, 4'd0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 33; i++) begin
      pdata = 8'(i);
      fire();
      wait_idle();
    end
    chk("R6 zero count runs 16", wa[15], 24'h20000F);
    chk("R10 first reload", wa[16], 24'h210010);
    chk("R10 second block end", wa[31], 24'h21001F);
    chk("R10 second reload", wa[32], 24'h200020);
    chk("R10 first table read", ra[16], 24'h001000);
    chk("R10 table advances", ra[33], 24'h001001);
    chk("R10 no irq", irq_n, 0);
    chk("R10 flag clears", clr_n, 33);
    chk("R10 enable kept", en_o, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tbl_mem[i] = 8'(i * 3 + 7);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_normal();
    t_pending();
    t_isel();
    t_chain();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule